// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. It runs a fixed subset of six instructions: register add and subtract that wrap and never trap, OR with a zero-extended immediate, word load, word store, and branch-if-equal. The core holds the program counter, a 32 x 32 register file with two combinational read ports and one clocked write port, an immediate extender, a three-function ALU, a hardwired decoder and the next-PC selection. Instruction memory and data memory are small word arrays. Both read combinationally and are written on the clock edge.

The program is written into instruction memory through a word-wide load port while reset is held. Each cycle the core reports the fetch address, the register write-back it is performing and the data-memory store it is performing. A surrounding system or a bench can follow execution from these ports alone.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset holds the program counter at 0. The first instruction executed after reset is the word at address 0.
- R2: Opcode 0x00 with funct 0x21 writes R[rd] = R[rs] + R[rt], and funct 0x23 writes R[rd] = R[rs] - R[rt], both modulo 2^32. The fields are rs = bits 25:21, rt = bits 20:16, rd = bits 15:11 and funct = bits 5:0. The opcode is in bits 31:26.
- R3: Opcode 0x0D writes R[rt] = R[rs] OR the zero-extended 16-bit immediate from bits 15:0.
- R4: Opcode 0x23 writes R[rt] with the data-memory word at R[rs] + the sign-extended immediate. The word index is taken from address bits above bit 1.
- R5: Opcode 0x2B stores R[rt] to the word at R[rs] + the sign-extended immediate. It makes no register write.
- R6: Opcode 0x04 compares R[rs] with R[rt] through the ALU subtraction. If they are equal, the next PC is PC + 4 + (sign-extended immediate x 4); otherwise it is PC + 4. The branch makes no register or memory write.
- R7: Register 0 always reads as zero. A write aimed at it has no effect.
- R8: Any other opcode, or opcode 0x00 with any other funct, acts as a no-op: no register write, no store, and PC + 4.
- R9: Every instruction other than a taken branch advances the PC by exactly 4 on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Instruction-memory load strobe |
| prog_addr | input | $clog2(IMEM_WORDS) | Word index being loaded |
| prog_data | input | 32 | Instruction word being loaded |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wb_en_o | output | 1 | The current instruction writes a register |
| wb_addr_o | output | 5 | Destination register number |
| wb_data_o | output | 32 | Value being written back |
| st_en_o | output | 1 | The current instruction stores to data memory |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
Every register and memory word feeds later instructions, so a wrong value written in one cycle appears at the write-back or store ports when a later instruction reads it. That is usually one to three instructions later, when a store or an arithmetic result carries it out. A wrong next-PC choice appears at pc_o on the very next cycle. A wrong decode appears at once as a write-back or store enable that should not be present. An ISA-level model in the bench runs in step with the core and compares all reported ports every cycle. The program sweeps operand pairs that exercise carry, borrow, sign extension and equality.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h21;
  localparam logic [5:0] FN_SUB = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    ext_sign;
    logic    use_imm;
    alu_op_e alu_op;
    logic    mem_wr;
    logic    mem_to_reg;
    logic    dst_rd;
    logic    reg_wr;
    logic    branch;
    logic    illegal;
  } ctrl_t;

  function automatic logic [XLEN-1:0] extend16(input logic [15:0] imm, input logic sign);
    extend16 = sign ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: alu_calc = a - b;
      ALU_OR:  alu_calc = a | b;
      default: alu_calc = a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    seq_pc = pc + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] br_target(input logic [XLEN-1:0] pc,
                                                input logic [XLEN-1:0] offs);
    br_target = pc + XLEN'(4) + {offs[XLEN-3:0], 2'b00};
  endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (op)
      OPC_RTYPE: begin
        ctl.dst_rd = 1'b1;
        if (funct == FN_ADD) begin
          ctl.reg_wr = 1'b1;
        end else if (funct == FN_SUB) begin
          ctl.reg_wr = 1'b1;
          ctl.alu_op = ALU_SUB;
        end else begin
          ctl.illegal = 1'b1;
        end
      end
      OPC_ORI: begin
        ctl.use_imm = 1'b1;
        ctl.alu_op  = ALU_OR;
        ctl.reg_wr  = 1'b1;
      end
      OPC_LOAD: begin
        ctl.ext_sign   = 1'b1;
        ctl.use_imm    = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_wr     = 1'b1;
      end
      OPC_STORE: begin
        ctl.ext_sign = 1'b1;
        ctl.use_imm  = 1'b1;
        ctl.mem_wr   = 1'b1;
      end
      OPC_BEQ: begin
        ctl.ext_sign = 1'b1;
        ctl.alu_op   = ALU_SUB;
        ctl.branch   = 1'b1;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
  import sc_core_pkg::*;
#(
  parameter int NREGS = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [$clog2(NREGS)-1:0] ra_a,
  input  logic [$clog2(NREGS)-1:0] ra_b,
  output logic [XLEN-1:0]         rd_a,
  output logic [XLEN-1:0]         rd_b
);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  assign y    = alu_calc(op, a, b);
  assign zero = (y == '0);

  always_comb begin
    if (op == ALU_SUB) begin
      // R6
      zero_eq_chk: assert (zero == (a == b));
    end
  end

endmodule

// File: rtl/sc_fetch.sv
module sc_fetch
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          prog_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] prog_addr,
  input  logic [XLEN-1:0]               prog_data,
  input  logic                          take_br,
  input  logic [XLEN-1:0]               br_offs,
  output logic [XLEN-1:0]               pc,
  output logic [XLEN-1:0]               instr
);

  localparam int IAW = $clog2(IMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] pc_next;

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  assign instr   = imem[pc[IAW+1:2]];
  assign pc_next = take_br ? br_target(pc, br_offs) : seq_pc(pc);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          prog_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] prog_addr,
  input  logic [31:0]                   prog_data,
  output logic [31:0]                   pc_o,
  output logic                          wb_en_o,
  output logic [4:0]                    wb_addr_o,
  output logic [31:0]                   wb_data_o,
  output logic                          st_en_o,
  output logic [31:0]                   st_addr_o,
  output logic [31:0]                   st_data_o
);

  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc, instr, imm_x, opa, opb, alu_b, alu_y, ld_data, wb_data;
  logic            alu_zero, take_br, rf_we, dm_we;
  logic [RIDX-1:0] rs, rt, rd, wa;
  ctrl_t           ctl;
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  assign rs = instr[25:21];
  assign rt = instr[20:16];
  assign rd = instr[15:11];

  sc_fetch #(.IMEM_WORDS(IMEM_WORDS)) u_fetch (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .take_br(take_br), .br_offs(imm_x),
    .pc(pc), .instr(instr)
  );

  sc_decode u_dec (.op(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

  assign imm_x = extend16(instr[15:0], ctl.ext_sign);

  sc_regbank #(.NREGS(32)) u_rf (
    .clk(clk), .we(rf_we), .waddr(wa), .wdata(wb_data),
    .ra_a(rs), .ra_b(rt), .rd_a(opa), .rd_b(opb)
  );

  assign alu_b = ctl.use_imm ? imm_x : opb;

  sc_alu u_alu (.op(ctl.alu_op), .a(opa), .b(alu_b), .y(alu_y), .zero(alu_zero));

  assign take_br = ctl.branch && alu_zero;
  assign ld_data = dmem[alu_y[DAW+1:2]];
  assign wb_data = ctl.mem_to_reg ? ld_data : alu_y;
  assign wa      = ctl.dst_rd ? rd : rt;
  assign rf_we   = ctl.reg_wr && !rst;
  assign dm_we   = ctl.mem_wr && !rst;

  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_y[DAW+1:2]] <= opb;
  end

  assign pc_o      = pc;
  assign wb_en_o   = rf_we;
  assign wb_addr_o = wa;
  assign wb_data_o = wb_data;
  assign st_en_o   = dm_we;
  assign st_addr_o = alu_y;
  assign st_data_o = opb;

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !take_br |=> pc == $past(pc) + 32'd4);

  // R6
  branch_target_chk: assert property (@(posedge clk) disable iff (rst)
    take_br |=> pc == $past(pc) + 32'd4 + {$past(imm_x[29:0]), 2'b00});

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.illegal |-> !rf_we && !dm_we);

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we);

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

  localparam int IW = 64;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        wb_en_o, st_en_o;
  logic [4:0]  wb_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] prog [IW];
  logic [31:0] mreg [32];
  logic [31:0] mdm  [DW];
  logic [31:0] mpc;

  always #2 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) uut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pc_o(pc_o), .wb_en_o(wb_en_o),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o), .st_en_o(st_en_o),
    .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, sx, npc, ewd, ead;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, ewa;
    logic        ewb, est;
    string       tag;
    ins = prog[mpc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a  = (rs == 0) ? 32'd0 : mreg[rs];
    b  = (rt == 0) ? 32'd0 : mreg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = mpc + 32'd4;
    ewb = 1'b0; est = 1'b0; ewa = '0; ewd = '0; ead = '0;
    tag = "R9";
    case (op)
      6'h00: begin
        if (fn == 6'h21) begin ewb = 1; ewa = rd; ewd = a + b; tag = "R2"; end
        else if (fn == 6'h23) begin ewb = 1; ewa = rd; ewd = a - b; tag = "R2"; end
        else tag = "R8";
      end
      6'h0D: begin ewb = 1; ewa = rt; ewd = a | {16'h0, ins[15:0]}; tag = "R3"; end
      6'h23: begin ead = a + sx; ewb = 1; ewa = rt; ewd = mdm[ead[7:2]]; tag = "R4"; end
      6'h2B: begin est = 1; ead = a + sx; ewd = b; tag = "R5"; end
      6'h04: begin tag = "R6"; if (a == b) npc = mpc + 32'd4 + {sx[29:0], 2'b00}; end
      default: tag = "R8";
    endcase
    if ((ewb && ewa == 0) || (op == 6'h00 && rs == 0 && rt == 0)) tag = "R7";
    check(tag, "pc", pc_o, mpc);
    check(tag, "wb_en", {31'd0, wb_en_o}, {31'd0, ewb});
    check(tag, "st_en", {31'd0, st_en_o}, {31'd0, est});
    if (ewb) begin
      check(tag, "wb_addr", {27'd0, wb_addr_o}, {27'd0, ewa});
      check(tag, "wb_data", wb_data_o, ewd);
    end
    if (est) begin
      check(tag, "st_addr", st_addr_o, ead);
      check(tag, "st_data", st_data_o, ewd);
    end
    if (ewb && ewa != 0) mreg[ewa] = ewd;
    if (est) mdm[ead[7:2]] = ewd;
    mpc = npc;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] va [4];
    logic [15:0] vb [4];
    int n;
    va = '{16'h0005, 16'hFFFF, 16'h8000, 16'h1234};
    vb = '{16'h0003, 16'h0001, 16'h8000, 16'hABCD};
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    for (int i = 0; i < DW; i++) mdm[i] = 32'h0;
    n = 0;
    prog[n++] = enc_i(6'h0D, 0, 6, 16'h0080);
    for (int k = 0; k < 4; k++) begin
      prog[n++] = enc_i(6'h0D, 0, 1, va[k]);
      prog[n++] = enc_i(6'h0D, 0, 2, vb[k]);
      prog[n++] = enc_r(1, 2, 3, 6'h21);
      prog[n++] = enc_r(1, 2, 4, 6'h23);
      prog[n++] = enc_i(6'h2B, 6, 4, 16'hFFF0 + 16'(4*k));
      prog[n++] = enc_i(6'h23, 6, 5, 16'hFFF0 + 16'(4*k));
      prog[n++] = enc_i(6'h2B, 6, 3, 16'(4*k));
    end
    prog[n++] = enc_i(6'h0D, 0, 0, 16'h0055);
    prog[n++] = enc_r(0, 0, 7, 6'h21);
    prog[n++] = enc_i(6'h04, 1, 2, 16'h0001);
    prog[n++] = enc_i(6'h04, 3, 3, 16'h0001);
    prog[n++] = enc_i(6'h0D, 0, 8, 16'hDEAD);
    prog[n++] = {6'h3F, 26'h155_5555};
    prog[n++] = enc_r(1, 2, 9, 6'h20);
    prog[n++] = enc_i(6'h23, 6, 10, 16'h0004);
    prog[n++] = enc_i(6'h04, 0, 0, 16'hFFFF);

    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    @(negedge clk);
    #1;
    // R1: PC held at zero under reset, no side effects reported
    check("R1", "pc_in_reset", pc_o, 32'd0);
    check("R1", "wb_in_reset", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    mpc = 32'd0;
    for (int c = 0; c < 80; c++) begin
      #1;
      model_step();
      @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule